// File: doc/BRIEF.md
# Ring-Chained FIFO Slice with Token Ownership

This block is one slice of a deep first-in first-out buffer that is built by joining several identical slices in a closed ring. No glue logic sits between them. Each slice holds a small local store. Two ownership tokens travel around the ring: one decides which slice accepts the next word, the other decides which slice supplies the next word. All slices see the same global write enable, read enable, write data and output enable. A slice acts only on the enables that match a token it holds, so words leave the ring in the order they entered.

The expansion link between neighbours has two active-low lanes, one for each token. A slice passes a token by pulling the matching lane low for exactly one clock, in the same cycle as the access that ends its turn. Every slice shares a single clock. The mode is chosen while reset is held. If both expansion-input lanes sit low, the slice works as a plain standalone FIFO. If the input is wired to a neighbour, it sees that neighbour's idle-high link and joins the ring. The first-load input marks the slice that starts out holding both tokens.

A write token leaves a slice that has just filled up. That slice's data then forms a closed segment. The read token leaves only after the last word of that segment has been read. A slice does not accept new writes while an older closed segment still waits in it. The output register is driven onto the shared bus through a drive-enable output. Only one slice in the ring asserts that output at any time.

Top module: `fifo_exp_slice`

## Requirements
- R1: The mode is captured on every clock while rst_n is low and is held after release. An expansion input of 2'b00 gives standalone mode; any other value gives ring mode.
- R2: After reset, a ring slice with fl_n low holds both tokens and one with fl_n high holds neither. The local store is empty, full_n is 1, empty_n is 0 and dout is 0.
- R3: The local store never overflows or underflows. full_n is low exactly when DEPTH words are stored, and empty_n is low exactly when none are stored.
- R4: In ring mode, a write that brings the store to DEPTH words, with no read of the same slice in that cycle, pulls xo_n[0] (the write lane) low during that cycle only. The slice then gives up the write token.
- R5: In ring mode, a read that takes the last word of the slice's closed segment pulls xo_n[1] (the read lane) low during that cycle only. The slice then gives up the read token.
- R6: In ring mode, xi_n[0] low at a clock edge hands the write token to the slice, and xi_n[1] low hands it the read token.
- R7: In ring mode, a slice without the write token ignores wr_en, and a slice without the read token ignores rd_en.
- R8: In ring mode, a slice that holds the write token ignores wr_en while words of its earlier closed segment remain unread.
- R9: drv is high only when oe_n is low and the slice owns the bus. In standalone mode the slice always owns it. In ring mode the owner is the read-token holder, except in the cycle right after a read-token handoff: then the slice that passed the token keeps the bus and the receiver does not drive. At most one ring slice has drv high.
- R10: dout shows the word taken by this slice's most recent accepted read and stays unchanged until the next one. Across the ring, the driven bus returns the words in the order they were written.
- R11: In standalone mode, xo_n stays 2'b11 and the slice works as a plain FIFO of DEPTH words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by writes, reads and links |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| fl_n | input | 1 | First-load select; low on the slice that starts with both tokens |
| xi_n | input | 2 | Expansion input from previous slice; bit 0 write lane, bit 1 read lane, active low |
| xo_n | output | 2 | Expansion output to next slice; bit 0 write lane, bit 1 read lane, active low |
| wr_en | input | 1 | Global write enable |
| din | input | W | Global write data |
| rd_en | input | 1 | Global read enable |
| oe_n | input | 1 | Global output enable, active low |
| dout | output | W | Output register of this slice |
| drv | output | 1 | Bus drive enable for dout |
| full_n | output | 1 | Low when the local store is full |
| empty_n | output | 1 | Low when the local store is empty |

## Verification
The assertions assume that every slice in a ring shares clk and rst_n. They also assume the link is wired as a closed ring, with exactly one slice having fl_n low, and that xi_n stays constant while reset is held. The bench keeps within this by joining three slices with one first-load slice and holding wr_en and rd_en low during reset. It changes inputs only at the falling clock edge. A standalone slice with xi_n tied to 2'b00 runs beside the ring on the same stimulus. A behavioural model made of per-slice queues, token indices and a single ordering queue predicts the flags, the link pulses, the drive pattern and the bus value every cycle.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
    typedef enum logic {
        MODE_ALONE = 1'b0,
        MODE_RING  = 1'b1
    } ring_mode_e;
endpackage

// File: rtl/fxs_store.sv
module fxs_store #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_A) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (!rst_n) begin
            p_d = '0;
        end else begin
            if (push) p_d.wp = bump(p_q.wp);
            if (pop)  p_d.rp = bump(p_q.rp);
            case ({push, pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[p_q.wp] <= wdata;
    end

    assign head = mem_q[p_q.rp];
    assign fill = p_q.cnt;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt == FULL_C) |-> !push);
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.cnt == '0) |-> !pop);
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (p_q.cnt <= FULL_C));
endmodule

// File: rtl/fxs_token.sv
module fxs_token
    import fxs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fl_n,
    input  logic [1:0]                 xi_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       push,
    output logic                       pop,
    output logic [1:0]                 xo_n,
    output logic                       bus_own
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] LAST_C = CW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    typedef struct packed {
        ring_mode_e    mode;
        logic          wtok;
        logic          rtok;
        logic [CW-1:0] seg;
        logic          fresh;
        logic          passed;
    } tok_t;

    tok_t st_d, st_q;
    logic ring, hand_w, hand_r;

    always_comb begin
        ring    = (st_q.mode == MODE_RING);
        push    = rst_n && wr_en && (fill != FULL_C)
                  && (!ring || (st_q.wtok && (st_q.seg == '0)));
        pop     = rst_n && rd_en && (fill != '0) && (!ring || st_q.rtok);
        hand_w  = ring && push && !pop && (fill == LAST_C);
        hand_r  = ring && pop && (st_q.seg == ONE_C);
        xo_n    = rst_n ? {~hand_r, ~hand_w} : 2'b11;
        bus_own = !ring || (st_q.rtok && !st_q.fresh) || st_q.passed;

        st_d = st_q;
        if (hand_w)                 st_d.wtok = 1'b0;
        else if (ring && !xi_n[0])  st_d.wtok = 1'b1;
        if (hand_r)                 st_d.rtok = 1'b0;
        else if (ring && !xi_n[1])  st_d.rtok = 1'b1;
        if (hand_w)                          st_d.seg = FULL_C;
        else if (pop && (st_q.seg != '0))    st_d.seg = st_q.seg - 1'b1;
        st_d.fresh  = ring && !xi_n[1];
        st_d.passed = hand_r;

        if (!rst_n) begin
            st_d.mode   = (xi_n != 2'b00) ? MODE_RING : MODE_ALONE;
            st_d.wtok   = ~fl_n;
            st_d.rtok   = ~fl_n;
            st_d.seg    = '0;
            st_d.fresh  = 1'b0;
            st_d.passed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.mode));
    a_r4_wr_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
        !xo_n[0] |=> xo_n[0]);
    a_r4_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
        !xo_n[0] |=> !st_q.wtok);
    a_r5_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
        !xo_n[1] |=> !st_q.rtok);
    a_r6_wr_take: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !xi_n[0] && xo_n[0]) |=> st_q.wtok);
    a_r6_rd_take: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !xi_n[1] && xo_n[1]) |=> st_q.rtok);
    a_r7_no_write_without_token: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !st_q.wtok) |-> !push);
    a_r7_no_read_without_token: assert property (@(posedge clk) disable iff (!rst_n)
        (ring && !st_q.rtok) |-> !pop);
    a_r8_closed_segment_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seg != '0) |-> !push);
    a_r11_alone_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ring |-> (xo_n == 2'b11));
endmodule

// File: rtl/fifo_exp_slice.sv
module fifo_exp_slice #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fl_n,
    input  logic [1:0]   xi_n,
    output logic [1:0]   xo_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    input  logic         rd_en,
    input  logic         oe_n,
    output logic [W-1:0] dout,
    output logic         drv,
    output logic         full_n,
    output logic         empty_n
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [W-1:0] q;
    } out_t;

    out_t          o_d, o_q;
    logic          push, pop, bus_own;
    logic [W-1:0]  head;
    logic [CW-1:0] fill;

    fxs_token #(.DEPTH(DEPTH)) i_token (
        .clk     (clk),
        .rst_n   (rst_n),
        .fl_n    (fl_n),
        .xi_n    (xi_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .fill    (fill),
        .push    (push),
        .pop     (pop),
        .xo_n    (xo_n),
        .bus_own (bus_own)
    );

    fxs_store #(.W(W), .DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (din),
        .head  (head),
        .fill  (fill)
    );

    always_comb begin
        o_d = o_q;
        if (!rst_n)   o_d.q = '0;
        else if (pop) o_d.q = head;
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign dout    = o_q.q;
    assign drv     = bus_own && !oe_n;
    assign full_n  = (fill != FULL_C);
    assign empty_n = (fill != '0);

    a_r10_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(dout));
    a_r9_no_drive_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv);
endmodule

// File: tb/test_fifo_exp_slice.sv
module test_fifo_exp_slice;
    localparam int PERIOD = 10;
    localparam int W = 9;
    localparam int D = 4;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, oe_n = 1'b0;
    logic [W-1:0] din = '0;

    logic [1:0]   xo [N];
    logic [1:0]   xi [N];
    logic [W-1:0] dq [N];
    logic         drv [N];
    logic         fulln [N];
    logic         emptyn [N];

    logic [1:0]   a_xo;
    logic [W-1:0] a_dq;
    logic         a_drv, a_fulln, a_emptyn;

    always #(PERIOD/2) clk = ~clk;

    for (genvar k = 0; k < N; k++) begin : g_ring
        assign xi[k] = xo[(k + N - 1) % N];
        fifo_exp_slice #(.W(W), .DEPTH(D)) i_fifo_exp_slice (
            .clk (clk), .rst_n (rst_n), .fl_n ((k == 0) ? 1'b0 : 1'b1),
            .xi_n (xi[k]), .xo_n (xo[k]), .wr_en (wr_en), .din (din),
            .rd_en (rd_en), .oe_n (oe_n), .dout (dq[k]), .drv (drv[k]),
            .full_n (fulln[k]), .empty_n (emptyn[k])
        );
    end

    fifo_exp_slice #(.W(W), .DEPTH(D)) i_fifo_exp_slice_alone (
        .clk (clk), .rst_n (rst_n), .fl_n (1'b0), .xi_n (2'b00), .xo_n (a_xo),
        .wr_en (wr_en), .din (din), .rd_en (rd_en), .oe_n (oe_n), .dout (a_dq),
        .drv (a_drv), .full_n (a_fulln), .empty_n (a_emptyn)
    );

    int tests = 0, fails = 0;
    bit done = 0;
    int mq [N][$];
    int seg [N];
    int wt = 0, rt = 0, own = 0;
    int gold [$];
    int aq [$];
    bit bus_v = 0, a_bus_v = 0;
    int exp_bus = 0, a_exp = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Checks all registered outputs against the model; called just after a falling edge.
    task automatic check_outputs();
        logic [W-1:0] bus;
        int ndrv;
        bus = '0;
        ndrv = 0;
        for (int k = 0; k < N; k++) begin
            chk(fulln[k] == (mq[k].size() != D), "R3 ring full_n", int'(fulln[k]), int'(mq[k].size() != D));
            chk(emptyn[k] == (mq[k].size() != 0), "R3 ring empty_n", int'(emptyn[k]), int'(mq[k].size() != 0));
            chk(drv[k] == (!oe_n && k == own), "R9 ring drive owner", int'(drv[k]), int'(!oe_n && k == own));
            if (drv[k]) begin
                bus = bus | dq[k];
                ndrv++;
            end
        end
        chk(ndrv <= 1, "R9 single driver", ndrv, 1);
        if (bus_v && !oe_n) chk(int'(bus) == exp_bus, "R10 ring order on bus", int'(bus), exp_bus);
        chk(a_fulln == (aq.size() != D), "R11 alone full_n", int'(a_fulln), int'(aq.size() != D));
        chk(a_emptyn == (aq.size() != 0), "R11 alone empty_n", int'(a_emptyn), int'(aq.size() != 0));
        chk(a_drv == !oe_n, "R9 alone drive", int'(a_drv), int'(!oe_n));
        if (a_bus_v) chk(int'(a_dq) == a_exp, "R10 alone dout", int'(a_dq), a_exp);
    endtask

    // Applies one cycle of stimulus, checks the link lanes, advances the model.
    task automatic step(input bit w, input bit r, input bit oe_hi, input logic [W-1:0] d);
        int s, rr;
        bit aw, ar, wpass, rpass, sw, sr;
        wr_en = w; rd_en = r; oe_n = oe_hi; din = d;
        #1;
        s = wt; rr = rt;
        aw = w && (mq[s].size() < D) && (seg[s] == 0);
        ar = r && (mq[rr].size() > 0);
        wpass = 0; rpass = 0;
        if (ar) begin
            void'(mq[rr].pop_front());
            exp_bus = gold.pop_front();
            if (seg[rr] > 0) begin
                seg[rr]--;
                if (seg[rr] == 0) rpass = 1;
            end
        end
        if (aw) begin
            mq[s].push_back(int'(d));
            gold.push_back(int'(d));
            if (mq[s].size() == D) begin
                wpass = 1;
                seg[s] = D;
            end
        end
        for (int k = 0; k < N; k++) begin
            chk(xo[k][0] == !(wpass && k == s), "R4 write lane pulse", int'(xo[k][0]), int'(!(wpass && k == s)));
            chk(xo[k][1] == !(rpass && k == rr), "R5 read lane pulse", int'(xo[k][1]), int'(!(rpass && k == rr)));
        end
        if (wpass) wt = (s + 1) % N;
        if (rpass) rt = (rr + 1) % N;
        own = rpass ? rr : rt;
        bus_v = ar;
        sw = w && (aq.size() < D);
        sr = r && (aq.size() > 0);
        if (sr) a_exp = aq.pop_front();
        if (sw) aq.push_back(int'(d));
        a_bus_v = sr;
        chk(a_xo == 2'b11, "R11 alone link idle", int'(a_xo), 3);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10 actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) seg[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state, slice 0 owns the bus
        for (int k = 0; k < N; k++) begin
            chk(emptyn[k] == 1'b0, "R2 reset empty", int'(emptyn[k]), 0);
            chk(fulln[k] == 1'b1, "R2 reset not full", int'(fulln[k]), 1);
            chk(dq[k] == '0, "R2 reset dout", int'(dq[k]), 0);
            chk(xo[k] == 2'b11, "R2 reset link idle", int'(xo[k]), 3);
        end
        check_outputs();

        // R1: ring slices with fl_n high stay out until handed the token; standalone fills alone
        for (int i = 0; i < D; i++) step(1, 0, 0, W'(10 + i));
        chk(emptyn[1] == 1'b0, "R1 R7 slice1 untouched before token", int'(emptyn[1]), 0);
        chk(a_fulln == 1'b0, "R1 standalone full without pulse", int'(a_fulln), 0);
        // R6: next write lands in slice 1
        step(1, 0, 0, W'(20));
        chk(emptyn[1] == 1'b1, "R6 write token taken by slice1", int'(emptyn[1]), 1);
        // R7: read served by slice 0 only
        step(0, 1, 0, W'(0));
        chk(mq[1].size() == 1 && emptyn[1] == 1'b1, "R7 slice1 ignores read", int'(emptyn[1]), 1);
        // fill the rest of the ring
        for (int i = 0; i < 2 * D; i++) step(1, 0, 0, W'(30 + i));
        // R8: write token back at slice 0 which still holds old words
        chk(wt == 0 && fulln[0] == 1'b1, "R8 slice0 has room", int'(fulln[0]), 1);
        step(1, 0, 0, W'(99));
        chk(emptyn[0] == 1'b1 && fulln[0] == 1'b1, "R8 write held off", int'(fulln[0]), 1);
        // R5 and R10: drain everything in order, then read when empty
        for (int i = 0; i < 3 * D + 2; i++) step(0, 1, 0, W'(0));
        for (int k = 0; k < N; k++)
            chk(emptyn[k] == 1'b0, "R3 drained empty", int'(emptyn[k]), 0);
        // R9: output enable high
        step(0, 0, 1, W'(0));

        for (int i = 0; i < 4000; i++)
            step(($urandom % 100) < 55, ($urandom % 100) < 50, ($urandom % 10) == 0, W'($urandom));
        for (int i = 0; i < 4 * D; i++) step(0, 1, 0, W'(0));

        done = 1;
        summary();
        $finish;
    end
endmodule